// File: doc/BRIEF.md
# Time-Multiplexed Zero-Delay LMS Adaptive Filter

This block is an N-tap direct-form adaptive FIR filter trained by the least-mean-square rule. It has no adaptation delay: the weight correction computed from one sample is already in force when the next sample's output is formed. There is a single bank of N signed multipliers, and it does two jobs for every sample. In the first cycle it multiplies the input vector by the weights and feeds the adder tree, which yields the output and the error. In the second cycle it multiplies the same input vector by the scaled error, and those products drive one weight adder per tap.

A source offers a sample `x_in` together with its desired response `d_in` and raises `in_valid`. The block takes it only in its accept cycle. One cycle later the block presents the output `y_out` and the error `e_out` with a one-cycle `out_valid` pulse. At most one sample can be taken every two clock cycles. Sample, weight and output words are two's-complement fixed-point values. The weights carry `W_FRAC` fraction bits and the samples carry `X_FRAC` fraction bits. The step size is the power of two 2^-`MU_SHIFT`.

Top module: `lms_tdm_filter`

## Requirements
- R1: On an accepted sample, `y_out` is the full-precision sum over k of w_k * x(n-k), with x(n) the sample just offered and x(n-k) the k-th most recent earlier accepted sample (zero when none). The sum is arithmetically shifted right by `W_FRAC` and then truncated to its low `DW` bits.
- R2: `e_out` equals `d_in - y_out`, wrapped to `DW` bits in two's complement.
- R3: The scaled error is `e_out` arithmetically shifted right by `MU_SHIFT`, which rounds toward minus infinity. No multiplier is used for it. For example, an error of -1 gives a scaled error of -1.
- R4: Each weight becomes w_k + ((scaled error * x(n-k)) >>> (2*`X_FRAC` - `W_FRAC`)). The input vector is the one that produced the error. The increment is truncated to `DW` bits and the sum wraps in two's complement.
- R5: The weights updated from one sample are the ones used to form the output of the very next accepted sample (zero adaptation delay).
- R6: When `in_valid` is high in the accept cycle, `y_out`, `e_out` and `out_valid` are registered at that rising edge. `out_valid` stays high for exactly one cycle, which is the update cycle. The cycle after that is an accept cycle again.
- R7: `in_valid` raised during the update cycle is ignored. No sample is taken, the delay line does not shift and `out_valid` falls.
- R8: While `in_valid` is low in the accept cycle, the delay line, the weights, `y_out` and `e_out` hold, and `out_valid` stays low.
- R9: A synchronous reset clears the weights, the delay line, the phase, `y_out`, `e_out` and `out_valid` to zero.
- R10: The input delay line shifts exactly once per accepted sample, however many idle cycles lie between samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Offers `x_in` and `d_in`; taken only in the accept cycle |
| x_in | input | DW | New input sample, signed, `X_FRAC` fraction bits |
| d_in | input | DW | Desired response for this sample, signed |
| out_valid | output | 1 | One-cycle pulse marking a new `y_out` and `e_out` |
| y_out | output | DW | Filter output, signed |
| e_out | output | DW | Error `d_in - y_out`, signed |

## Verification
The bench builds the filter with five taps. Five is not a power of two, so the adder tree has to pad three leaves with zeros. The other settings are a step shift of 2, 8 sample fraction bits and 10 weight fraction bits, which gives a weight increment shift of 6. With full-scale samples, the weights reach their wrap point within a few updates, and the output and error wrap as well. This puts the two's-complement overflow paths within reach of a short directed run. Small hand-computed cases pin down the floor rounding of the error shift and the zero-delay use of a fresh weight. A reference model then follows long sequences that mix idle gaps, ignored offers in the update cycle and a reset in mid-run.

// File: rtl/lms_tdm_pkg.sv
package lms_tdm_pkg;
   // Two-cycle sequence for every accepted sample
   typedef enum logic {
      PH_ERR = 1'b0,   // accept cycle: products go to the adder tree
      PH_UPD = 1'b1    // update cycle: products go to the weight adders
   } lms_phase_t;

   function automatic int unsigned tree_leaves(input int unsigned n);
      return 1 << $clog2(n);
   endfunction
endpackage

// File: rtl/lms_tap_line.sv
module lms_tap_line #(
   parameter int NTAPS = 8,
   parameter int DW    = 12
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       shift_en,
   input  logic [DW-1:0]              din,
   output logic [NTAPS-1:0][DW-1:0]   taps
);
   // taps[0] holds the newest accepted sample
   always_ff @(posedge clk) begin
      if (rst) begin
         taps <= '0;
      end else if (shift_en) begin
         taps <= {taps[NTAPS-2:0], din};
      end
   end
endmodule

// File: rtl/lms_mac_bank.sv
module lms_mac_bank #(
   parameter int NTAPS     = 8,
   parameter int DW        = 12,
   parameter int INC_SHIFT = 6
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        upd,
   input  logic [NTAPS-1:0][DW-1:0]    xvec,
   input  logic [DW-1:0]               mu_err,
   output logic [NTAPS-1:0][DW-1:0]    weights,
   output logic [NTAPS-1:0][2*DW-1:0]  fir_prod
);
   localparam int PW = 2 * DW;

   for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      logic signed [DW-1:0] w_q;
      logic signed [DW-1:0] coef_op;
      logic signed [PW-1:0] prod;
      logic signed [PW-1:0] upd_prod;

      // operand multiplexer: weight in the accept cycle, scaled error in the update cycle
      assign coef_op = upd ? $signed(mu_err) : w_q;
      assign prod    = $signed(xvec[k]) * coef_op;

      // product demultiplexer
      assign fir_prod[k] = upd ? '0 : prod;
      assign upd_prod    = upd ? prod : '0;

      always_ff @(posedge clk) begin
         if (rst) begin
            w_q <= '0;
         end else if (upd) begin
            w_q <= w_q + DW'(upd_prod >>> INC_SHIFT);
         end
      end

      assign weights[k] = w_q;
   end
endmodule

// File: rtl/lms_adder_tree.sv
module lms_adder_tree #(
   parameter int NTAPS = 8,
   parameter int IW    = 24,
   parameter int OW    = 27
) (
   input  logic [NTAPS-1:0][IW-1:0] terms,
   output logic [OW-1:0]            sum
);
   import lms_tdm_pkg::*;
   localparam int P  = tree_leaves(NTAPS);
   localparam int LV = $clog2(P);

   for (genvar l = 0; l <= LV; l++) begin : g_lvl
      logic signed [OW-1:0] s [0:(P>>l)-1];
      if (l == 0) begin : g_leaf
         for (genvar i = 0; i < P; i++) begin : g_in
            if (i < NTAPS) begin : g_used
               assign s[i] = {{(OW-IW){terms[i][IW-1]}}, terms[i]};
            end else begin : g_pad
               assign s[i] = '0;
            end
         end
      end else begin : g_add
         for (genvar i = 0; i < (P>>l); i++) begin : g_node
            assign s[i] = g_lvl[l-1].s[2*i] + g_lvl[l-1].s[2*i+1];
         end
      end
   end

   assign sum = g_lvl[LV].s[0];
endmodule

// File: rtl/lms_tdm_filter.sv
module lms_tdm_filter #(
   parameter int NTAPS    = 8,
   parameter int DW       = 12,
   parameter int X_FRAC   = 8,
   parameter int W_FRAC   = 10,
   parameter int MU_SHIFT = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [DW-1:0] x_in,
   input  logic [DW-1:0] d_in,
   output logic          out_valid,
   output logic [DW-1:0] y_out,
   output logic [DW-1:0] e_out
);
   import lms_tdm_pkg::*;

   localparam int PW        = 2 * DW;
   localparam int AW        = PW + $clog2(tree_leaves(NTAPS));
   localparam int INC_SHIFT = 2 * X_FRAC - W_FRAC;

   // elaboration-time parameter checks
   if (NTAPS < 2) begin : g_bad_ntaps
      $error("NTAPS must be at least 2");
   end
   if (DW < 4) begin : g_bad_dw
      $error("DW must be at least 4");
   end
   if (MU_SHIFT < 0 || MU_SHIFT >= DW) begin : g_bad_mu
      $error("MU_SHIFT must lie in [0, DW)");
   end
   if (INC_SHIFT < 0 || INC_SHIFT >= PW) begin : g_bad_inc
      $error("2*X_FRAC - W_FRAC must lie in [0, 2*DW)");
   end
   if (W_FRAC + DW > AW) begin : g_bad_wfrac
      $error("W_FRAC too large for the accumulator width");
   end

   lms_phase_t ph;
   logic ph_upd;
   logic accept;

   logic [NTAPS-1:0][DW-1:0]   taps;
   logic [NTAPS-1:0][DW-1:0]   xvec;
   logic [NTAPS-1:0][DW-1:0]   weights;
   logic [NTAPS-1:0][2*DW-1:0] fir_prod;
   logic signed [AW-1:0]       acc_sum;
   logic signed [DW-1:0]       y_now;
   logic signed [DW-1:0]       e_now;
   logic signed [DW-1:0]       mu_e_now;
   logic        [DW-1:0]       mu_e_q;
   logic [DW-1:0]              tap_head;
   logic [DW-1:0]              w_first;

   assign ph_upd = (ph == PH_UPD);
   assign accept = in_valid && !ph_upd;

   lms_tap_line #(.NTAPS(NTAPS), .DW(DW)) u_line (
      .clk      (clk),
      .rst      (rst),
      .shift_en (accept),
      .din      (x_in),
      .taps     (taps)
   );

   // In the accept cycle the vector is the offered sample plus the older taps;
   // in the update cycle it is the shifted line, which holds the same values.
   for (genvar k = 0; k < NTAPS; k++) begin : g_vec
      if (k == 0) begin : g_head
         assign xvec[k] = ph_upd ? taps[0] : x_in;
      end else begin : g_rest
         assign xvec[k] = ph_upd ? taps[k] : taps[k-1];
      end
   end

   lms_mac_bank #(.NTAPS(NTAPS), .DW(DW), .INC_SHIFT(INC_SHIFT)) u_mac (
      .clk      (clk),
      .rst      (rst),
      .upd      (ph_upd),
      .xvec     (xvec),
      .mu_err   (mu_e_q),
      .weights  (weights),
      .fir_prod (fir_prod)
   );

   lms_adder_tree #(.NTAPS(NTAPS), .IW(PW), .OW(AW)) u_tree (
      .terms (fir_prod),
      .sum   (acc_sum)
   );

   assign y_now    = DW'(acc_sum >>> W_FRAC);
   assign e_now    = $signed(d_in) - y_now;
   assign mu_e_now = e_now >>> MU_SHIFT;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph        <= PH_ERR;
         out_valid <= 1'b0;
         y_out     <= '0;
         e_out     <= '0;
         mu_e_q    <= '0;
      end else begin
         out_valid <= accept;
         if (accept) begin
            ph     <= PH_UPD;
            y_out  <= y_now;
            e_out  <= e_now;
            mu_e_q <= mu_e_now;   // register that breaks the adaptation loop
         end else begin
            ph <= PH_ERR;
         end
      end
   end

   assign tap_head = taps[0];
   assign w_first  = weights[0];
endmodule

// File: rtl/lms_tdm_filter_chk.sv
module lms_tdm_filter_chk #(
   parameter int DW = 12
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic [DW-1:0] x_in,
   input logic          out_valid,
   input logic [DW-1:0] y_out,
   input logic [DW-1:0] e_out,
   input logic          phase_upd,
   input logic [DW-1:0] tap_head,
   input logic [DW-1:0] w_first
);
   // R6
   accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (!phase_upd && in_valid) |=> (out_valid && phase_upd));

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   // R7
   upd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      phase_upd |=> ($stable(tap_head) && !phase_upd && !out_valid));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!phase_upd && !in_valid) |=>
         ($stable(y_out) && $stable(e_out) && $stable(tap_head) && $stable(w_first) && !out_valid));

   // R4
   weight_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      !phase_upd |=> $stable(w_first));

   // R10
   shift_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
      (!phase_upd && in_valid) |=> (tap_head == $past(x_in)));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!phase_upd && !out_valid && tap_head == '0 && w_first == '0 && y_out == '0 && e_out == '0));
endmodule

bind lms_tdm_filter lms_tdm_filter_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .x_in      (x_in),
   .out_valid (out_valid),
   .y_out     (y_out),
   .e_out     (e_out),
   .phase_upd (ph_upd),
   .tap_head  (tap_head),
   .w_first   (w_first)
);

// File: tb/test_lms_tdm_filter.sv
`timescale 1ns/1ps
module test_lms_tdm_filter;
   localparam int NTAPS    = 5;
   localparam int DW       = 12;
   localparam int X_FRAC   = 8;
   localparam int W_FRAC   = 10;
   localparam int MU_SHIFT = 2;
   localparam int INC      = 2 * X_FRAC - W_FRAC;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [DW-1:0] x_in = '0;
   logic [DW-1:0] d_in = '0;
   logic out_valid;
   logic signed [DW-1:0] y_out;
   logic signed [DW-1:0] e_out;

   int nchk = 0;
   int nerr = 0;
   int mw [NTAPS];
   int mx [NTAPS];
   int unsigned seed = 32'h1234_5678;

   always #2 clk = ~clk;

   lms_tdm_filter #(
      .NTAPS(NTAPS), .DW(DW), .X_FRAC(X_FRAC), .W_FRAC(W_FRAC), .MU_SHIFT(MU_SHIFT)
   ) i_lms_tdm_filter (
      .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in), .d_in(d_in),
      .out_valid(out_valid), .y_out(y_out), .e_out(e_out)
   );

   function automatic int wrapw(longint v);
      logic signed [DW-1:0] t;
      t = v[DW-1:0];
      return int'(t);
   endfunction

   function automatic int rnd12();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 8) & 32'hFFF) - 2048;
   endfunction

   task automatic chk(string tag, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int k = 0; k < NTAPS; k++) begin
         mw[k] = 0;
         mx[k] = 0;
      end
   endtask

   // Reference model of one accepted sample, built from R1 to R4
   task automatic model_step(int xv, int dv, output int ey, output int ee);
      int vec [NTAPS];
      longint acc;
      int mue;
      vec[0] = xv;
      for (int k = 1; k < NTAPS; k++) vec[k] = mx[k-1];
      acc = 0;
      for (int k = 0; k < NTAPS; k++) acc += longint'(vec[k]) * longint'(mw[k]);
      ey  = wrapw(acc >>> W_FRAC);
      ee  = wrapw(longint'(dv) - longint'(ey));
      mue = ee >>> MU_SHIFT;
      for (int k = 0; k < NTAPS; k++)
         mw[k] = wrapw(longint'(mw[k]) + longint'(wrapw((longint'(mue) * longint'(vec[k])) >>> INC)));
      for (int k = 0; k < NTAPS; k++) mx[k] = vec[k];
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      model_clear();
   endtask

   // offers one sample; optionally offers junk in the update cycle
   task automatic send(int xv, int dv, string tg, bit junk, output int gy, output int ge);
      int ey, ee;
      model_step(xv, dv, ey, ee);
      @(negedge clk);
      in_valid = 1'b1;
      x_in = xv[DW-1:0];
      d_in = dv[DW-1:0];
      @(negedge clk);
      if (junk) begin
         in_valid = 1'b1;
         x_in = 12'h3A5;
         d_in = 12'h5C1;
      end else begin
         in_valid = 1'b0;
      end
      gy = int'(y_out);
      ge = int'(e_out);
      chk({"R6 out_valid ", tg}, int'(out_valid), 1);
      chk({"R1 y ", tg}, gy, ey);
      chk({"R2 e ", tg}, ge, ee);
      if (junk) begin
         @(negedge clk);
         in_valid = 1'b0;
         chk({"R7 out_valid after ignored offer ", tg}, int'(out_valid), 0);
      end
   endtask

   task automatic idle(int n);
      int hy, he;
      hy = int'(y_out);
      he = int'(e_out);
      repeat (n) begin
         @(negedge clk);
         chk("R8 idle out_valid", int'(out_valid), 0);
      end
      chk("R8 idle y hold", int'(y_out), hy);
      chk("R8 idle e hold", int'(e_out), he);
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R9 reset out_valid", int'(out_valid), 0);
      chk("R9 reset y", int'(y_out), 0);
      chk("R9 reset e", int'(e_out), 0);
   endtask

   task automatic t_first_sample();
      int gy, ge;
      do_reset();
      send(700, -300, "first", 1'b0, gy, ge);
      chk("R2 first e equals d", ge, -300);
   endtask

   task automatic t_zero_delay();
      int gy, ge;
      do_reset();
      send(256, 256, "zd a", 1'b0, gy, ge);
      send(256, 0, "zd b", 1'b0, gy, ge);
      chk("R5 fresh weight used by next sample", gy, 64);
   endtask

   task automatic t_floor_shift();
      int gy, ge;
      do_reset();
      send(256, -1, "fl a", 1'b0, gy, ge);
      send(256, 0, "fl b", 1'b0, gy, ge);
      chk("R3 floor of negative error", gy, -1);
   endtask

   task automatic t_ignore_offer();
      int gy, ge;
      do_reset();
      for (int i = 0; i < 8; i++) send(rnd12(), rnd12(), "R7 ign", 1'b1, gy, ge);
      for (int i = 0; i < 4; i++) send(rnd12(), rnd12(), "R7 after", 1'b0, gy, ge);
   endtask

   task automatic t_idle_gaps();
      int gy, ge;
      do_reset();
      for (int i = 0; i < 20; i++) begin
         send(rnd12() / 4, rnd12() / 4, "R10 gap", 1'b0, gy, ge);
         idle(i % 4);
      end
   endtask

   task automatic t_wrap();
      int gy, ge;
      do_reset();
      for (int i = 0; i < 12; i++) send(2047, 2047, "R4 grow", 1'b0, gy, ge);
      for (int i = 0; i < 12; i++) send(-2048, (i % 2) ? 2047 : -2048, "R4 wrap", 1'b0, gy, ge);
   endtask

   task automatic t_train_mid_reset();
      int gy, ge;
      do_reset();
      for (int i = 0; i < 60; i++) send(rnd12() / 2, rnd12() / 2, "R4 train", 1'b0, gy, ge);
      do_reset();
      send(500, 123, "R9 after reset", 1'b0, gy, ge);
      chk("R9 cleared weights give zero y", gy, 0);
      send(-400, 77, "R9 second", 1'b0, gy, ge);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      t_reset_state();
      t_first_sample();
      t_zero_delay();
      t_floor_shift();
      t_ignore_offer();
      t_idle_gaps();
      t_wrap();
      t_train_mid_reset();
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule